// File: doc/BRIEF.md
# Coherence-Mode Memory Request Router

This per-tile block sits between a core's memory pipeline and two possible servers: the tile's own cache hierarchy, which may consult a directory behind it, and a remote tile reached by a request/reply pair over the on-chip network. A one-bit mode register chooses how the tile keeps memory coherent. It comes up in directory mode. A dedicated update port can switch it to shared-cache mode at the end of a protocol transition. Loading a new application forces it back to directory mode.

Each request comes with the home-core field of the translation entry that covers its 4 KB page. The router exposes the page number so that the entry can be looked up in the same cycle. In directory mode every request goes to the local hierarchy. In shared-cache mode a request whose home core is another tile becomes a remote transaction tagged with this tile's ID, and any other request goes local. In both modes the router flags a core miss whenever the home core differs from this tile, so that profiling logic can judge the alternative protocol. The router holds one request at a time: the core stalls until the matching reply comes back.

Top module: `cohRouter`

## Requirements
- R1: After reset, and one cycle after `appLoad` is high, `modeShared` is 0 (directory mode). `appLoad` wins over a mode write in the same cycle.
- R2: A mode write (`modeWrEn` high, `appLoad` low) sets `modeShared` to `modeWrVal` from the next cycle on. A request accepted in the same cycle as a mode write is routed by the mode held before the write.
- R3: `pageNum` always equals `reqAddr` with its low 12 bits (the 4 KB page offset) dropped.
- R4: A request accepted in directory mode goes to the local port, whatever its home core.
- R5: A request accepted in shared-cache mode whose `xlatHome` equals `myCoreId` goes to the local port.
- R6: A request accepted in shared-cache mode whose `xlatHome` differs from `myCoreId` raises `remoteValid` the next cycle, with `remoteDest` = home, `remoteSrc` = `myCoreId`, and the captured address, write flag and write data. It holds them until `remoteReady` is seen.
- R7: `coreMiss` is high for exactly the one cycle after a request is accepted whose home core differs from `myCoreId`, in either mode, and is low otherwise.
- R8: `reqReady` is low from the cycle after acceptance until the reply is delivered. `rspValid` is high for one cycle, the cycle after the reply arrives, with `rspData` equal to the reply data, and `reqReady` is high again in that same cycle.
- R9: A remote reply whose `remoteRspSrc` differs from the home core of the outstanding request, or one that arrives while no remote request is outstanding, produces no `rspValid` and does not end the stall.
- R10: `localValid` and `remoteValid` are never high together. The local request, with its address, write flag and write data, is held until `localReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| myCoreId | input | 7 | ID of this tile (static) |
| appLoad | input | 1 | New application loaded; forces directory mode |
| modeWrEn | input | 1 | Mode update strobe at end of protocol transition |
| modeWrVal | input | 1 | New mode: 0 directory, 1 shared-cache |
| modeShared | output | 1 | Current mode register |
| reqValid | input | 1 | Core memory request valid |
| reqReady | output | 1 | Router idle, request accepted |
| reqAddr | input | 32 | Request address |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqWdata | input | 32 | Store data |
| pageNum | output | 20 | Page number for translation lookup |
| xlatHome | input | 7 | Home core from translation entry |
| coreMiss | output | 1 | One-cycle core-miss flag for profiling |
| localValid | output | 1 | Request to local cache hierarchy |
| localReady | input | 1 | Local hierarchy takes request |
| localAddr | output | 32 | Local request address |
| localWrite | output | 1 | Local request write flag |
| localWdata | output | 32 | Local request write data |
| localRspValid | input | 1 | Local reply valid |
| localRspData | input | 32 | Local reply data |
| remoteValid | output | 1 | Remote request valid |
| remoteReady | input | 1 | Network takes remote request |
| remoteDest | output | 7 | Destination (home) tile |
| remoteSrc | output | 7 | Requester tile ID |
| remoteAddr | output | 32 | Remote request address |
| remoteWrite | output | 1 | Remote request write flag |
| remoteWdata | output | 32 | Remote request write data |
| remoteRspValid | input | 1 | Remote reply valid |
| remoteRspSrc | input | 7 | Tile the reply came from |
| remoteRspData | input | 32 | Remote reply data |
| rspValid | output | 1 | Reply to core |
| rspData | output | 32 | Reply data to core |

## Verification
A mode update and a request acceptance can fall in the same cycle, and so can an application load and a mode update. The bench provokes the first by presenting a request with a foreign home core in directory mode in the same cycle as a write to shared-cache mode. It expects the request on the local port, a core miss, and shared-cache mode reported one cycle later. It provokes the second by raising `appLoad` and a shared-mode write together, and expects directory mode afterwards. A reply that carries the wrong source tag is also offered while a remote request waits, and the bench checks that the stall continues.

// File: rtl/coh_route_pkg.sv
package coh_route_pkg;

  typedef enum logic {
    MODE_DIR    = 1'b0,
    MODE_SHARED = 1'b1
  } cohMode_t;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LOC_REQ  = 3'd1,
    ST_LOC_WAIT = 3'd2,
    ST_REM_REQ  = 3'd3,
    ST_REM_WAIT = 3'd4
  } routeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic takeLocalRsp;
    logic takeRemoteRsp;
  } dpStrobe_t;

endpackage

// File: rtl/cohRouteDatapath.sv
module cohRouteDatapath
  import coh_route_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 7,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strobe,
  input  logic [CORE_W-1:0]         myCoreId,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic                      reqWrite,
  input  logic [DATA_W-1:0]         reqWdata,
  input  logic [CORE_W-1:0]         xlatHome,
  input  logic [DATA_W-1:0]         localRspData,
  input  logic [CORE_W-1:0]         remoteRspSrc,
  input  logic [DATA_W-1:0]         remoteRspData,
  output logic [ADDR_W-PAGE_BITS-1:0] pageNum,
  output logic                      homeDiffers,
  output logic                      rspMatch,
  output logic [ADDR_W-1:0]         heldAddr,
  output logic                      heldWrite,
  output logic [DATA_W-1:0]         heldWdata,
  output logic [CORE_W-1:0]         heldHome,
  output logic [CORE_W-1:0]         heldSrc,
  output logic [DATA_W-1:0]         rspData
);

  localparam int PAGE_W = ADDR_W - PAGE_BITS;

  // page number drives the translation lookup in the request cycle
  assign pageNum     = reqAddr[ADDR_W-1:PAGE_BITS];
  assign homeDiffers = (xlatHome != myCoreId);
  assign rspMatch    = (remoteRspSrc == heldHome);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr  <= '0;
      heldWrite <= 1'b0;
      heldWdata <= '0;
      heldHome  <= '0;
      heldSrc   <= '0;
    end else if (strobe.capture) begin
      heldAddr  <= reqAddr;
      heldWrite <= reqWrite;
      heldWdata <= reqWdata;
      heldHome  <= xlatHome;
      heldSrc   <= myCoreId;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspData <= '0;
    end else if (strobe.takeLocalRsp) begin
      rspData <= localRspData;
    end else if (strobe.takeRemoteRsp) begin
      rspData <= remoteRspData;
    end
  end

  // R6: captured request fields stay put while a transaction is outstanding
  p_held_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(heldAddr) && $stable(heldHome) && $stable(heldWdata)));

  // R3: page number has PAGE_W bits
  initial begin
    p_page_width_r3: assert (PAGE_W > 0);
  end

endmodule

// File: rtl/cohRouteCtrl.sv
module cohRouteCtrl
  import coh_route_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      appLoad,
  input  logic      modeWrEn,
  input  logic      modeWrVal,
  input  logic      reqValid,
  input  logic      homeDiffers,
  input  logic      localReady,
  input  logic      localRspValid,
  input  logic      remoteReady,
  input  logic      remoteRspValid,
  input  logic      rspMatch,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      localValid,
  output logic      remoteValid,
  output logic      coreMiss,
  output logic      rspValid,
  output logic      modeShared
);

  cohMode_t    modeReg;
  routeState_t state, stateNext;
  logic        accept;
  logic        goRemote;

  assign reqReady   = (state == ST_IDLE);
  assign accept     = reqValid && reqReady;
  assign goRemote   = (modeReg == MODE_SHARED) && homeDiffers;
  assign localValid = (state == ST_LOC_REQ);
  assign remoteValid = (state == ST_REM_REQ);
  assign modeShared = (modeReg == MODE_SHARED);

  always_comb begin
    strobe.capture       = accept;
    strobe.takeLocalRsp  = (state == ST_LOC_WAIT) && localRspValid;
    strobe.takeRemoteRsp = (state == ST_REM_WAIT) && remoteRspValid && rspMatch;
  end

  // mode register: application load has priority over transition update
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_DIR;
    end else if (appLoad) begin
      modeReg <= MODE_DIR;
    end else if (modeWrEn) begin
      modeReg <= cohMode_t'(modeWrVal);
    end
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (accept) stateNext = goRemote ? ST_REM_REQ : ST_LOC_REQ;
      ST_LOC_REQ:  if (localReady) stateNext = ST_LOC_WAIT;
      ST_LOC_WAIT: if (strobe.takeLocalRsp) stateNext = ST_IDLE;
      ST_REM_REQ:  if (remoteReady) stateNext = ST_REM_WAIT;
      ST_REM_WAIT: if (strobe.takeRemoteRsp) stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      coreMiss <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      state    <= stateNext;
      coreMiss <= accept && homeDiffers;
      rspValid <= strobe.takeLocalRsp || strobe.takeRemoteRsp;
    end
  end

  p_appload_dir_r1: assert property (@(posedge clk) disable iff (!rstN)
    appLoad |=> !modeShared);

  p_mode_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !appLoad) |=> (modeShared == $past(modeWrVal)));

  p_dir_local_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !modeShared) |=> (localValid && !remoteValid));

  p_miss_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreMiss |=> !coreMiss);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_one_path_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(localValid && remoteValid));

  p_local_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (localValid && !localReady) |=> localValid);

endmodule

// File: rtl/cohRouter.sv
module cohRouter
  import coh_route_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CORE_W    = 7,
  parameter int PAGE_BITS = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [CORE_W-1:0]           myCoreId,
  input  logic                        appLoad,
  input  logic                        modeWrEn,
  input  logic                        modeWrVal,
  output logic                        modeShared,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWrite,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic [ADDR_W-PAGE_BITS-1:0] pageNum,
  input  logic [CORE_W-1:0]           xlatHome,
  output logic                        coreMiss,
  output logic                        localValid,
  input  logic                        localReady,
  output logic [ADDR_W-1:0]           localAddr,
  output logic                        localWrite,
  output logic [DATA_W-1:0]           localWdata,
  input  logic                        localRspValid,
  input  logic [DATA_W-1:0]           localRspData,
  output logic                        remoteValid,
  input  logic                        remoteReady,
  output logic [CORE_W-1:0]           remoteDest,
  output logic [CORE_W-1:0]           remoteSrc,
  output logic [ADDR_W-1:0]           remoteAddr,
  output logic                        remoteWrite,
  output logic [DATA_W-1:0]           remoteWdata,
  input  logic                        remoteRspValid,
  input  logic [CORE_W-1:0]           remoteRspSrc,
  input  logic [DATA_W-1:0]           remoteRspData,
  output logic                        rspValid,
  output logic [DATA_W-1:0]           rspData
);

  dpStrobe_t          strobe;
  logic               homeDiffers;
  logic               rspMatch;
  logic [ADDR_W-1:0]  heldAddr;
  logic               heldWrite;
  logic [DATA_W-1:0]  heldWdata;
  logic [CORE_W-1:0]  heldHome;
  logic [CORE_W-1:0]  heldSrc;

  cohRouteCtrl ctrl_i (
    .clk            (clk),
    .rstN           (rstN),
    .appLoad        (appLoad),
    .modeWrEn       (modeWrEn),
    .modeWrVal      (modeWrVal),
    .reqValid       (reqValid),
    .homeDiffers    (homeDiffers),
    .localReady     (localReady),
    .localRspValid  (localRspValid),
    .remoteReady    (remoteReady),
    .remoteRspValid (remoteRspValid),
    .rspMatch       (rspMatch),
    .strobe         (strobe),
    .reqReady       (reqReady),
    .localValid     (localValid),
    .remoteValid    (remoteValid),
    .coreMiss       (coreMiss),
    .rspValid       (rspValid),
    .modeShared     (modeShared)
  );

  cohRouteDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CORE_W    (CORE_W),
    .PAGE_BITS (PAGE_BITS)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .myCoreId      (myCoreId),
    .reqAddr       (reqAddr),
    .reqWrite      (reqWrite),
    .reqWdata      (reqWdata),
    .xlatHome      (xlatHome),
    .localRspData  (localRspData),
    .remoteRspSrc  (remoteRspSrc),
    .remoteRspData (remoteRspData),
    .pageNum       (pageNum),
    .homeDiffers   (homeDiffers),
    .rspMatch      (rspMatch),
    .heldAddr      (heldAddr),
    .heldWrite     (heldWrite),
    .heldWdata     (heldWdata),
    .heldHome      (heldHome),
    .heldSrc       (heldSrc),
    .rspData       (rspData)
  );

  assign localAddr   = heldAddr;
  assign localWrite  = heldWrite;
  assign localWdata  = heldWdata;
  assign remoteDest  = heldHome;
  assign remoteSrc   = heldSrc;
  assign remoteAddr  = heldAddr;
  assign remoteWrite = heldWrite;
  assign remoteWdata = heldWdata;

  // R6: a remote request never targets this tile
  p_remote_dest_r6: assert property (@(posedge clk) disable iff (!rstN)
    remoteValid |-> (remoteDest != remoteSrc));

  // R9: a reply is delivered only after a request was outstanding
  p_rsp_after_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(!reqReady));

endmodule

// File: tb/cohRouter_tb_top.sv
module cohRouter_tb_top;

  localparam logic [6:0] ME = 7'd21;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        appLoad = 0, modeWrEn = 0, modeWrVal = 0;
  logic        modeShared;
  logic        reqValid = 0, reqReady, reqWrite = 0;
  logic [31:0] reqAddr = 0, reqWdata = 0;
  logic [19:0] pageNum;
  logic [6:0]  xlatHome = 0;
  logic        coreMiss;
  logic        localValid, localReady = 0, localWrite;
  logic [31:0] localAddr, localWdata;
  logic        localRspValid = 0;
  logic [31:0] localRspData = 0;
  logic        remoteValid, remoteReady = 0, remoteWrite;
  logic [6:0]  remoteDest, remoteSrc;
  logic [31:0] remoteAddr, remoteWdata;
  logic        remoteRspValid = 0;
  logic [6:0]  remoteRspSrc = 0;
  logic [31:0] remoteRspData = 0;
  logic        rspValid;
  logic [31:0] rspData;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cohRouter dut_i (
    .clk(clk), .rstN(rstN), .myCoreId(ME), .appLoad(appLoad),
    .modeWrEn(modeWrEn), .modeWrVal(modeWrVal), .modeShared(modeShared),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqWdata(reqWdata), .pageNum(pageNum),
    .xlatHome(xlatHome), .coreMiss(coreMiss),
    .localValid(localValid), .localReady(localReady), .localAddr(localAddr),
    .localWrite(localWrite), .localWdata(localWdata),
    .localRspValid(localRspValid), .localRspData(localRspData),
    .remoteValid(remoteValid), .remoteReady(remoteReady),
    .remoteDest(remoteDest), .remoteSrc(remoteSrc), .remoteAddr(remoteAddr),
    .remoteWrite(remoteWrite), .remoteWdata(remoteWdata),
    .remoteRspValid(remoteRspValid), .remoteRspSrc(remoteRspSrc),
    .remoteRspData(remoteRspData), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 100000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      summary();
    end
  end

  // present a request for one cycle, optionally with a mode write beside it
  task automatic issue(input logic [31:0] addr, input logic wr, input logic [31:0] wd,
                       input logic [6:0] home, input logic mWr, input logic mVal,
                       input logic expRemote, input logic expMiss);
    @(negedge clk);
    reqValid = 1; reqAddr = addr; reqWrite = wr; reqWdata = wd; xlatHome = home;
    modeWrEn = mWr; modeWrVal = mVal;
    #1;
    chk("R3 pageNum", pageNum, addr >> 12);
    chk("R8 reqReady idle", reqReady, 1);
    @(negedge clk);
    reqValid = 0; modeWrEn = 0;
    chk("R7 coreMiss after accept", coreMiss, expMiss);
    chk("R8 reqReady busy", reqReady, 0);
    chk("R10 remoteValid routing", remoteValid, expRemote);
    chk("R10 localValid routing", localValid, !expRemote);
    if (expRemote) begin
      chk("R6 remoteDest", remoteDest, home);
      chk("R6 remoteSrc", remoteSrc, ME);
      chk("R6 remoteAddr", remoteAddr, addr);
      chk("R6 remoteWrite", remoteWrite, wr);
      chk("R6 remoteWdata", remoteWdata, wd);
    end else begin
      chk("R10 localAddr", localAddr, addr);
      chk("R10 localWrite", localWrite, wr);
      chk("R10 localWdata", localWdata, wd);
    end
  endtask

  task automatic finishLocal(input logic [31:0] data);
    @(negedge clk);
    chk("R10 local held without ready", localValid, 1);
    chk("R7 coreMiss single cycle", coreMiss, 0);
    localReady = 1;
    @(negedge clk);
    localReady = 0;
    chk("R10 local dropped after ready", localValid, 0);
    localRspValid = 1; localRspData = data;
    @(negedge clk);
    localRspValid = 0;
    chk("R8 rspValid local", rspValid, 1);
    chk("R8 rspData local", rspData, data);
    chk("R8 reqReady after reply", reqReady, 1);
    @(negedge clk);
    chk("R8 rspValid one cycle", rspValid, 0);
  endtask

  task automatic finishRemote(input logic [6:0] home, input logic [31:0] data);
    @(negedge clk);
    chk("R6 remote held without ready", remoteValid, 1);
    chk("R7 coreMiss single cycle", coreMiss, 0);
    remoteReady = 1;
    @(negedge clk);
    remoteReady = 0;
    chk("R6 remote dropped after ready", remoteValid, 0);
    remoteRspValid = 1; remoteRspSrc = home ^ 7'd1; remoteRspData = ~data;
    @(negedge clk);
    remoteRspValid = 0;
    chk("R9 wrong-source reply ignored", rspValid, 0);
    chk("R9 stall continues", reqReady, 0);
    remoteRspValid = 1; remoteRspSrc = home; remoteRspData = data;
    @(negedge clk);
    remoteRspValid = 0;
    chk("R8 rspValid remote", rspValid, 1);
    chk("R8 rspData remote", rspData, data);
    chk("R8 reqReady after reply", reqReady, 1);
  endtask

  task automatic setMode(input logic val, input logic load);
    @(negedge clk);
    modeWrEn = 1; modeWrVal = val; appLoad = load;
    @(negedge clk);
    modeWrEn = 0; appLoad = 0;
    chk(load ? "R1 appLoad wins" : "R2 mode write", modeShared, load ? 0 : val);
  endtask

  task automatic testReset();
    chk("R1 reset mode", modeShared, 0);
    chk("R8 reset reqReady", reqReady, 1);
    chk("R10 reset localValid", localValid, 0);
    chk("R10 reset remoteValid", remoteValid, 0);
    chk("R7 reset coreMiss", coreMiss, 0);
    chk("R8 reset rspValid", rspValid, 0);
  endtask

  task automatic testIdleReply();
    @(negedge clk);
    remoteRspValid = 1; remoteRspSrc = 7'd0; remoteRspData = 32'hDEAD;
    @(negedge clk);
    remoteRspValid = 0;
    chk("R9 idle reply ignored", rspValid, 0);
    chk("R9 idle reply reqReady", reqReady, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    // R4: directory mode, local home and foreign home
    issue(32'h0001_2345, 1'b0, 32'h0, ME, 0, 0, 0, 0);
    finishLocal(32'hA1A1_0001);
    issue(32'hFFFF_F00C, 1'b1, 32'h1234_5678, 7'd90, 0, 0, 0, 1);
    finishLocal(32'hA1A1_0002);
    // R2: switch to shared mode
    setMode(1'b1, 1'b0);
    // R5: shared mode, own home
    issue(32'h0000_1FFF, 1'b1, 32'hCAFE_0000, ME, 0, 0, 0, 0);
    finishLocal(32'hB2B2_0003);
    // R6: shared mode, foreign homes
    issue(32'h8000_4000, 1'b1, 32'h5555_AAAA, 7'd90, 0, 0, 1, 1);
    finishRemote(7'd90, 32'hC3C3_0004);
    issue(32'h7654_3210, 1'b0, 32'h0, 7'd0, 0, 0, 1, 1);
    finishRemote(7'd0, 32'hC3C3_0005);
    testIdleReply();
    // R1: application load beats a simultaneous mode write
    setMode(1'b1, 1'b1);
    issue(32'h0ABC_0000, 1'b0, 32'h0, 7'd127, 0, 0, 0, 1);
    finishLocal(32'hD4D4_0006);
    // R2: mode write in the acceptance cycle uses the old mode
    issue(32'h1111_2222, 1'b1, 32'h3333_4444, 7'd90, 1, 1, 0, 1);
    chk("R2 mode updated beside request", modeShared, 1);
    finishLocal(32'hE5E5_0007);
    issue(32'h1111_3000, 1'b0, 32'h0, 7'd90, 0, 0, 1, 1);
    finishRemote(7'd90, 32'hE5E5_0008);
    // R2: back to directory mode
    setMode(1'b0, 1'b0);
    issue(32'h2222_0000, 1'b0, 32'h0, 7'd5, 0, 0, 0, 1);
    finishLocal(32'hF6F6_0009);
    summary();
  end

endmodule